// File: doc/BRIEF.md
# Multi-channel USB host transfer tracker

This block keeps the state of eight USB host pipes side by side. Each channel stores the target device's characteristics (address, endpoint, direction, transfer type, speed, maximum packet size and frame parity for periodic work) and the parameters of one transfer: remaining bytes, remaining packets and the starting data PID. Software programs a channel through a small per-channel register port and then sets its enable bit. From then on the transaction engine reports each finished packet with a pulse and a byte count, and the channel counts the transfer down by itself.

When the last packet finishes, or when software asks the channel to stop, the channel drops its enable bit. It reports transfer complete and halted in an interrupt status word that has a matching mask. It becomes free for new programming only once the halted event has been reported. The scheduler sees every channel's live characteristics and counters on flat output buses, and a single interrupt line gathers all unmasked status bits.

Top module: `usb_hcb_top`

## Requirements
- R1: After reset every channel is free and not active, all stored fields, counters, status and mask bits read zero, and `irq` is low.
- R2: A characteristics write (select 0) to a free channel stores bits 10:0 max packet size, 14:11 endpoint, 15 IN direction, 17:16 transfer type, 18 low speed, 25:19 device address and 26 odd frame. A 1 in bit 31 makes the channel active from the next edge, and bit 31 then reads 1 while it is active.
- R3: A transfer write (select 1) to a free channel stores bits 18:0 byte count, 28:19 packet count and 30:29 initial PID, and reads back in the same layout.
- R4: While a channel is not free, a transfer write leaves the packet count, the byte count and the PID unchanged.
- R5: Each packet-done pulse on a non-free channel lowers its packet count by one and its byte count by the reported bytes, stopping at zero.
- R6: On the edge where the packet count reaches zero, status bit 0 (transfer complete) sets and the channel stops being active. Enabling a channel whose packet count is already zero sets bit 0 on that same edge.
- R7: A stopped channel sets status bit 1 (halted) and becomes free on the first edge on which the engine's busy flag is low. It is never free earlier, so a completed transfer is free one edge after it reports complete.
- R8: A characteristics write with bit 30 set to an active channel stops it from the next edge, and bit 30 reads 1 until the halt. Packets still in flight keep counting down, and transfer complete stays clear.
- R9: Status bits are cleared by writing 1 to them (select 2). A status event in the same cycle as a clear of that bit wins.
- R10: `ch_int_stat` carries each channel's two status bits at positions 2*ch and 2*ch+1. `irq` is high exactly when some status bit has its mask bit (select 3) set.
- R11: A write or packet event on one channel changes no other channel.
- R12: A characteristics write to a channel that is not free changes none of its stored fields; only a bit 30 disable request acts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wr_ch | input | 3 | Channel written |
| reg_wr_sel | input | 2 | Word written: 0 characteristics, 1 transfer, 2 status clear, 3 mask |
| reg_wr_data | input | 32 | Write data |
| reg_rd_ch | input | 3 | Channel read |
| reg_rd_sel | input | 2 | Word read, same encoding as writes |
| reg_rd_data | output | 32 | Read data, combinational |
| eng_pkt_busy | input | 8 | Per channel: engine has a packet in flight |
| eng_pkt_done | input | 8 | Per channel: one packet finished this cycle |
| eng_pkt_bytes | input | 88 | Per channel: bytes moved by the finished packet, 11 bits each |
| ch_active | output | 8 | Per channel enable state |
| ch_free | output | 8 | Per channel: free for new programming |
| ch_int_stat | output | 16 | Raw status, two bits per channel |
| irq | output | 1 | OR of all unmasked status bits |
| sched_char | output | 256 | Characteristics word of each channel, 32 bits each |
| sched_xfer | output | 256 | Transfer word of each channel, 32 bits each |

## Verification
Two functions meet in one cycle when the final packet of a transfer completes on the same edge that software writes 1 to clear the transfer-complete bit. The bench drives both in a single cycle and expects the bit to read 1 afterwards, with `irq` high under the mask. A second collision puts a packet completion on a channel that is stopping after a disable request while the engine still reports busy. There the counters must step down, the halt must wait until busy falls, and transfer complete must stay clear.

// File: rtl/usb_hcb_pkg.sv
// Package: shared widths, register selects, channel states and the
// characteristics layout used by every module of the host channel bank.
// Assumes a 32-bit register word.
package usb_hcb_pkg;

    localparam int REG_W   = 32;
    localparam int MPS_W   = 11;
    localparam int BYTES_W = 19;
    localparam int PKT_W   = 10;
    localparam int PID_W   = 2;
    localparam int STAT_W  = 2;

    // bit positions inside register words
    localparam int EN_BIT   = 31;
    localparam int DIS_BIT  = 30;
    localparam int ST_XFRC  = 0;
    localparam int ST_HALT  = 1;

    typedef enum logic [1:0] {
        SEL_CHAR = 2'd0,
        SEL_XFER = 2'd1,
        SEL_STAT = 2'd2,
        SEL_MASK = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        CH_IDLE   = 2'd0,
        CH_ACTIVE = 2'd1,
        CH_STOP   = 2'd2
    } ch_state_e;

    // 27 bits, first field is the most significant
    typedef struct packed {
        logic       odd_frame;
        logic [6:0] dev_addr;
        logic       low_speed;
        logic [1:0] xfer_type;
        logic       dir_in;
        logic [3:0] ep_num;
        logic [MPS_W-1:0] mps;
    } chan_char_t;

    localparam int CHAR_W = $bits(chan_char_t);

endpackage

// File: rtl/usb_hcb_chan.sv
// Module: one host channel. Holds characteristics, transfer counters,
// status and mask, and runs the idle/active/stopping sequence.
// Assumes wr_en is already decoded for this channel and that the engine
// raises pkt_done for one cycle per finished packet.
module usb_hcb_chan
    import usb_hcb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              pkt_busy,
    input  logic              pkt_done,
    input  logic [MPS_W-1:0]  pkt_bytes,
    output logic [REG_W-1:0]  char_word,
    output logic [REG_W-1:0]  xfer_word,
    output logic [STAT_W-1:0] stat,
    output logic [STAT_W-1:0] mask,
    output logic              active,
    output logic              free
);

    ch_state_e              state_q;
    chan_char_t             char_q;
    logic [PKT_W-1:0]       pkt_q;
    logic [BYTES_W-1:0]     bytes_q;
    logic [PID_W-1:0]       pid_q;
    logic [STAT_W-1:0]      stat_q;
    logic [STAT_W-1:0]      mask_q;

    logic wr_char, wr_xfer, wr_stat, wr_mask;
    logic en_req, dis_req, counting, last_pkt, zero_start;
    logic set_xfrc, set_halt;
    logic [STAT_W-1:0]  set_vec, clr_vec;
    logic [BYTES_W-1:0] pkt_bytes_ext;
    logic unused_wr_bits;

    // decode which word of this channel is written
    always_comb begin
        wr_char = wr_en && (wr_sel == SEL_CHAR);
        wr_xfer = wr_en && (wr_sel == SEL_XFER);
        wr_stat = wr_en && (wr_sel == SEL_STAT);
        wr_mask = wr_en && (wr_sel == SEL_MASK);
    end

    assign unused_wr_bits = ^wr_data[29:27];

    // derive the events that move the channel
    always_comb begin
        en_req        = wr_char && wr_data[EN_BIT];
        dis_req       = wr_char && wr_data[DIS_BIT];
        counting      = pkt_done && (state_q != CH_IDLE);
        last_pkt      = counting && (pkt_q == PKT_W'(1));
        zero_start    = (state_q == CH_IDLE) && en_req && (pkt_q == '0);
        set_xfrc      = last_pkt || zero_start;
        set_halt      = (state_q == CH_STOP) && !pkt_busy;
        pkt_bytes_ext = BYTES_W'(pkt_bytes);
    end

    // channel sequence: idle -> active -> stopping -> idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
        end else begin
            case (state_q)
                CH_IDLE: begin
                    if (en_req) begin
                        state_q <= (pkt_q == '0) ? CH_STOP : CH_ACTIVE;
                    end
                end
                CH_ACTIVE: begin
                    if (last_pkt || dis_req) begin
                        state_q <= CH_STOP;
                    end
                end
                CH_STOP: begin
                    if (!pkt_busy) begin
                        state_q <= CH_IDLE;
                    end
                end
                default: state_q <= CH_IDLE;
            endcase
        end
    end

    // characteristics are taken only while the channel is free
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            char_q <= '0;
        end else if (wr_char && (state_q == CH_IDLE)) begin
            char_q <= chan_char_t'(wr_data[CHAR_W-1:0]);
        end
    end

    // transfer counters: loaded while free, counted down while busy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pkt_q   <= '0;
            bytes_q <= '0;
            pid_q   <= '0;
        end else if (wr_xfer && (state_q == CH_IDLE)) begin
            bytes_q <= wr_data[BYTES_W-1:0];
            pkt_q   <= wr_data[BYTES_W +: PKT_W];
            pid_q   <= wr_data[BYTES_W+PKT_W +: PID_W];
        end else if (counting) begin
            pkt_q   <= (pkt_q == '0) ? '0 : pkt_q - PKT_W'(1);
            bytes_q <= (bytes_q > pkt_bytes_ext) ? bytes_q - pkt_bytes_ext : '0;
        end
    end

    // status: write-1-to-clear, a same-cycle event wins
    always_comb begin
        set_vec          = '0;
        set_vec[ST_XFRC] = set_xfrc;
        set_vec[ST_HALT] = set_halt;
        clr_vec          = wr_stat ? wr_data[STAT_W-1:0] : '0;
    end

    // status and mask registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
            mask_q <= '0;
        end else begin
            stat_q <= (stat_q & ~clr_vec) | set_vec;
            if (wr_mask) begin
                mask_q <= wr_data[STAT_W-1:0];
            end
        end
    end

    // pack the visible words
    always_comb begin
        char_word                   = '0;
        char_word[CHAR_W-1:0]       = char_q;
        char_word[EN_BIT]           = (state_q == CH_ACTIVE);
        char_word[DIS_BIT]          = (state_q == CH_STOP) && !stat_q[ST_XFRC];
        xfer_word                   = '0;
        xfer_word[BYTES_W-1:0]      = bytes_q;
        xfer_word[BYTES_W +: PKT_W] = pkt_q;
        xfer_word[BYTES_W+PKT_W +: PID_W] = pid_q;
        stat   = stat_q;
        mask   = mask_q;
        active = (state_q == CH_ACTIVE);
        free   = (state_q == CH_IDLE);
    end

    AST_XFER_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != CH_IDLE && wr_xfer && !pkt_done) |=> $stable(pkt_q)) // R4
        else $error("transfer write changed a busy channel");

    AST_PKT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_ACTIVE && pkt_done) |=> (pkt_q == $past(pkt_q) - PKT_W'(1))) // R5
        else $error("packet count did not step by one");

    AST_ACTIVE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_ACTIVE) |-> (pkt_q != '0)) // R6
        else $error("active channel with no packets left");

    AST_FREE_AFTER_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == CH_IDLE) |-> stat_q[ST_HALT]) // R7
        else $error("channel freed without halted status");

    AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_STOP && !pkt_busy) |=> (state_q == CH_IDLE && stat_q[ST_HALT])) // R8
        else $error("stopping channel did not halt");

endmodule

// File: rtl/usb_hcb_irq.sv
// Module: interrupt combiner. ORs every status bit whose mask bit is set
// across all channels into one line. Purely combinational.
module usb_hcb_irq
    import usb_hcb_pkg::*;
#(
    parameter int NUM_CH = 8
)(
    input  logic [NUM_CH-1:0][STAT_W-1:0] stat,
    input  logic [NUM_CH-1:0][STAT_W-1:0] mask,
    output logic                          irq
);

    logic [NUM_CH-1:0] ch_hit;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_hit
        // per-channel unmasked event
        assign ch_hit[g] = |(stat[g] & mask[g]);
    end

    // gather the channel hits
    assign irq = |ch_hit;

endmodule

// File: rtl/usb_hcb_rdmux.sv
// Module: register read multiplexer. Selects one word of one channel.
// Assumes an out-of-range channel number reads as zero.
module usb_hcb_rdmux
    import usb_hcb_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int CH_W   = $clog2(NUM_CH)
)(
    input  logic [NUM_CH-1:0][REG_W-1:0]  char_w,
    input  logic [NUM_CH-1:0][REG_W-1:0]  xfer_w,
    input  logic [NUM_CH-1:0][STAT_W-1:0] stat_w,
    input  logic [NUM_CH-1:0][STAT_W-1:0] mask_w,
    input  logic [CH_W-1:0]               rd_ch,
    input  logic [1:0]                    rd_sel,
    output logic [REG_W-1:0]              rd_data
);

    // choose the addressed word
    always_comb begin
        rd_data = '0;
        if (32'(rd_ch) < NUM_CH) begin
            case (rd_sel)
                SEL_CHAR: rd_data = char_w[rd_ch];
                SEL_XFER: rd_data = xfer_w[rd_ch];
                SEL_STAT: rd_data = REG_W'(stat_w[rd_ch]);
                default:  rd_data = REG_W'(mask_w[rd_ch]);
            endcase
        end
    end

endmodule

// File: rtl/usb_hcb_top.sv
// Module: bank of host channels. Decodes register writes per channel,
// routes engine events, flattens channel state for the scheduler and
// combines interrupts. Assumes one register write per cycle.
module usb_hcb_top
    import usb_hcb_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int CH_W   = $clog2(NUM_CH)
)(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      reg_wr,
    input  logic [CH_W-1:0]           reg_wr_ch,
    input  logic [1:0]                reg_wr_sel,
    input  logic [REG_W-1:0]          reg_wr_data,
    input  logic [CH_W-1:0]           reg_rd_ch,
    input  logic [1:0]                reg_rd_sel,
    output logic [REG_W-1:0]          reg_rd_data,
    input  logic [NUM_CH-1:0]         eng_pkt_busy,
    input  logic [NUM_CH-1:0]         eng_pkt_done,
    input  logic [NUM_CH*MPS_W-1:0]   eng_pkt_bytes,
    output logic [NUM_CH-1:0]         ch_active,
    output logic [NUM_CH-1:0]         ch_free,
    output logic [NUM_CH*STAT_W-1:0]  ch_int_stat,
    output logic                      irq,
    output logic [NUM_CH*REG_W-1:0]   sched_char,
    output logic [NUM_CH*REG_W-1:0]   sched_xfer
);

    logic [NUM_CH-1:0][REG_W-1:0]  char_w;
    logic [NUM_CH-1:0][REG_W-1:0]  xfer_w;
    logic [NUM_CH-1:0][STAT_W-1:0] stat_w;
    logic [NUM_CH-1:0][STAT_W-1:0] mask_w;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic wr_hit;

        // per-channel write strobe
        assign wr_hit = reg_wr && (32'(reg_wr_ch) == g);

        usb_hcb_chan u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (wr_hit),
            .wr_sel    (reg_wr_sel),
            .wr_data   (reg_wr_data),
            .pkt_busy  (eng_pkt_busy[g]),
            .pkt_done  (eng_pkt_done[g]),
            .pkt_bytes (eng_pkt_bytes[g*MPS_W +: MPS_W]),
            .char_word (char_w[g]),
            .xfer_word (xfer_w[g]),
            .stat      (stat_w[g]),
            .mask      (mask_w[g]),
            .active    (ch_active[g]),
            .free      (ch_free[g])
        );
    end

    // flatten channel state for the scheduler and status outputs
    assign sched_char  = char_w;
    assign sched_xfer  = xfer_w;
    assign ch_int_stat = stat_w;

    usb_hcb_irq #(.NUM_CH(NUM_CH)) u_irq (
        .stat (stat_w),
        .mask (mask_w),
        .irq  (irq)
    );

    usb_hcb_rdmux #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_rdmux (
        .char_w  (char_w),
        .xfer_w  (xfer_w),
        .stat_w  (stat_w),
        .mask_w  (mask_w),
        .rd_ch   (reg_rd_ch),
        .rd_sel  (reg_rd_sel),
        .rd_data (reg_rd_data)
    );

    AST_ONE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_active & ch_free) == '0) // R7
        else $error("channel both active and free");

endmodule

// File: tb/usb_hcb_top_bench.sv
`timescale 1ns/1ps
module usb_hcb_top_bench;

    localparam int NCH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_wr_ch = '0;
    logic [1:0]  reg_wr_sel = '0;
    logic [31:0] reg_wr_data = '0;
    logic [2:0]  reg_rd_ch = '0;
    logic [1:0]  reg_rd_sel = '0;
    logic [31:0] reg_rd_data;
    logic [7:0]  eng_pkt_busy = '0;
    logic [7:0]  eng_pkt_done = '0;
    logic [87:0] eng_pkt_bytes = '0;
    logic [7:0]  ch_active, ch_free;
    logic [15:0] ch_int_stat;
    logic        irq;
    logic [255:0] sched_char, sched_xfer;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    typedef struct {
        int          kind;   // 0 reg read, 1 active, 2 free, 3 irq, 4 int_stat
        int          ch;
        int          sel;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];

    usb_hcb_top u_usb_hcb_top (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_wr_ch(reg_wr_ch), .reg_wr_sel(reg_wr_sel),
        .reg_wr_data(reg_wr_data), .reg_rd_ch(reg_rd_ch), .reg_rd_sel(reg_rd_sel),
        .reg_rd_data(reg_rd_data), .eng_pkt_busy(eng_pkt_busy),
        .eng_pkt_done(eng_pkt_done), .eng_pkt_bytes(eng_pkt_bytes),
        .ch_active(ch_active), .ch_free(ch_free), .ch_int_stat(ch_int_stat),
        .irq(irq), .sched_char(sched_char), .sched_xfer(sched_xfer)
    );

    always #4 clk = ~clk;

    function automatic logic [31:0] mk_char(input int odd, input int addr, input int ls,
                                             input int typ, input int din, input int ep,
                                             input int mps);
        return 32'((odd << 26) | (addr << 19) | (ls << 18) | (typ << 16) |
                   (din << 15) | (ep << 11) | mps);
    endfunction

    function automatic logic [31:0] mk_xfer(input int pid, input int pkt, input int bytes);
        return 32'((pid << 29) | (pkt << 19) | bytes);
    endfunction

    task automatic push(input int kind, input int ch, input int sel,
                        input logic [31:0] exp, input string tag);
        item_t it;
        it.kind = kind; it.ch = ch; it.sel = sel; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
    endtask

    // let the monitor drain the queue at the next negative edge
    task automatic sync();
        @(negedge clk);
        #3;
    endtask

    task automatic wr(input int ch, input int sel, input logic [31:0] data);
        @(negedge clk);
        reg_wr = 1'b1; reg_wr_ch = 3'(ch); reg_wr_sel = 2'(sel); reg_wr_data = data;
        @(posedge clk);
        #1 reg_wr = 1'b0;
    endtask

    task automatic pkt(input int ch, input int bytes);
        @(negedge clk);
        eng_pkt_done[ch] = 1'b1;
        eng_pkt_bytes[ch*11 +: 11] = 11'(bytes);
        @(posedge clk);
        #1 eng_pkt_done[ch] = 1'b0;
    endtask

    // last packet and a status clear on the same edge
    task automatic pkt_and_clear(input int ch, input int bytes, input logic [31:0] clr);
        @(negedge clk);
        eng_pkt_done[ch] = 1'b1;
        eng_pkt_bytes[ch*11 +: 11] = 11'(bytes);
        reg_wr = 1'b1; reg_wr_ch = 3'(ch); reg_wr_sel = 2'd2; reg_wr_data = clr;
        @(posedge clk);
        #1;
        eng_pkt_done[ch] = 1'b0;
        reg_wr = 1'b0;
    endtask

    // monitor: pops expected items and compares against the design
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb_q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = sb_q.pop_front();
                case (it.kind)
                    0: begin
                        reg_rd_ch = 3'(it.ch);
                        reg_rd_sel = 2'(it.sel);
                        #0.1;
                        act = reg_rd_data;
                    end
                    1: act = 32'(ch_active);
                    2: act = 32'(ch_free);
                    3: act = 32'(irq);
                    default: act = 32'(ch_int_stat);
                endcase
                checks++;
                if (act !== it.exp) begin
                    failures++;
                    $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] c2, c6;
        c2 = mk_char(1, 'h11, 0, 2, 1, 5, 128);
        c6 = mk_char(0, 3, 1, 0, 0, 1, 64);

        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        push(1, 0, 0, 32'h0, "R1 active");
        push(2, 0, 0, 32'hFF, "R1 free");
        push(3, 0, 0, 32'h0, "R1 irq");
        push(4, 0, 0, 32'h0, "R1 int_stat");
        push(0, 0, 1, 32'h0, "R1 xfer ch0");
        push(0, 3, 3, 32'h0, "R1 mask ch3");
        sync();

        // R3 transfer programming
        wr(2, 1, mk_xfer(2, 3, 300));
        push(0, 2, 1, mk_xfer(2, 3, 300), "R3 xfer readback");
        sync();

        // R2 characteristics and enable
        wr(2, 0, c2 | 32'h8000_0000);
        push(0, 2, 0, c2 | 32'h8000_0000, "R2 char readback");
        push(1, 0, 0, 32'h04, "R2 active");
        push(2, 0, 0, 32'hFB, "R2 free");
        sync();

        // R4 transfer write ignored while busy
        wr(2, 1, mk_xfer(0, 9, 5));
        push(0, 2, 1, mk_xfer(2, 3, 300), "R4 xfer locked");
        sync();

        // R12 characteristics write ignored while busy
        wr(2, 0, mk_char(0, 'h22, 1, 1, 0, 7, 8));
        push(0, 2, 0, c2 | 32'h8000_0000, "R12 char locked");
        sync();

        wr(2, 3, 32'h3);
        push(0, 2, 3, 32'h3, "R10 mask readback");
        sync();

        // R5 countdown
        pkt(2, 128);
        push(0, 2, 1, mk_xfer(2, 2, 172), "R5 first packet");
        sync();
        pkt(2, 128);
        push(0, 2, 1, mk_xfer(2, 1, 44), "R5 second packet");
        push(0, 5, 1, 32'h0, "R11 ch5 xfer untouched");
        push(0, 5, 0, 32'h0, "R11 ch5 char untouched");
        sync();

        // R6 R9 last packet collides with a clear of bit 0
        pkt_and_clear(2, 100, 32'h1);
        push(0, 2, 1, mk_xfer(2, 0, 0), "R5 saturate bytes");
        push(0, 2, 2, 32'h1, "R9 set wins over clear");
        push(1, 0, 0, 32'h0, "R6 enable dropped");
        push(2, 0, 0, 32'hFB, "R7 not free before halt");
        push(3, 0, 0, 32'h1, "R10 irq on masked bit");
        push(4, 0, 0, 32'h10, "R10 int_stat layout");
        sync();
        push(0, 2, 2, 32'h3, "R7 halted set");
        push(2, 0, 0, 32'hFF, "R7 free after halt");
        push(0, 2, 0, c2, "R6 char enable clear");
        sync();

        // R9 write-1-to-clear
        wr(2, 2, 32'h3);
        push(0, 2, 2, 32'h0, "R9 cleared");
        push(3, 0, 0, 32'h0, "R10 irq low");
        sync();

        // R8 disable request with a packet in flight
        wr(6, 1, mk_xfer(1, 5, 1000));
        wr(6, 0, c6 | 32'h8000_0000);
        @(negedge clk) eng_pkt_busy[6] = 1'b1;
        wr(6, 0, c6 | 32'h4000_0000);
        push(1, 0, 0, 32'h0, "R8 stopped");
        push(0, 6, 0, c6 | 32'h4000_0000, "R8 stopping flag");
        push(0, 6, 2, 32'h0, "R8 no halt while busy");
        push(2, 0, 0, 32'hBF, "R8 not free while busy");
        sync();
        pkt(6, 64);
        push(0, 6, 1, mk_xfer(1, 4, 936), "R8 in-flight packet counted");
        sync();
        eng_pkt_busy[6] = 1'b0;
        sync();
        push(0, 6, 2, 32'h2, "R8 halted only");
        push(2, 0, 0, 32'hFF, "R8 free");
        push(4, 0, 0, 32'h2000, "R10 int_stat ch6");
        push(3, 0, 0, 32'h0, "R10 masked off");
        sync();

        // R6 enable with zero packets
        wr(1, 0, 32'h8000_0000);
        push(0, 1, 2, 32'h1, "R6 zero-packet complete");
        push(2, 0, 0, 32'hFD, "R7 zero-packet not free");
        sync();
        push(0, 1, 2, 32'h3, "R6 zero-packet halted");
        push(2, 0, 0, 32'hFF, "R7 zero-packet free");
        sync();

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule